// File: doc/BRIEF.md
# Clock-Derived Gated Pulse Counter

This block turns the rate of an incoming pulse train into a binary code. It opens a measurement window whose length is a programmed number of master-clock cycles and counts the rising edges of the pulse input that arrive while the window is open. The window comes from the same clock that sets the pulse source's full-scale rate. The code therefore depends only on the ratio of the two frequencies, and drift of the clock cancels out.

The pulse input is asynchronous. It is brought into the clock domain through a synchronizer chain before its rising edges are detected. A window can be started once with a start request, or windows can run back to back while continuous mode is held. At each window close the count is placed in a result register and held there. A one-cycle valid strobe marks the new result, and an overflow flag is set if the count hit its ceiling. A build-time option subtracts one tenth of the window length from each result, saturating at zero, so that a source idling at 10% of the clock rate reads as zero.

The window length sets the resolution: full-scale counts are the window length times the peak pulse rate. The length can also be picked to span whole periods of a mains interference tone so that the tone averages out. Because the window is not aligned to the pulses, a result can differ by one count from the ideal.

Top module: `gated_pulse_counter`

## Requirements
- R1: While rst_n is low, and right after it is released, count_out is 0 and count_valid, count_ovf and gate_active are 0.
- R2: A start (or continuous) request seen at a clock edge while idle with gate_len non-zero raises gate_active for exactly gate_len cycles. count_valid is high for exactly one cycle, the cycle right after the last gate cycle.
- R3: Pulse edges that arrive while no window is open are not counted. count_out holds its last result, and count_valid stays low, until the next window closes.
- R4: Each clean pulse on pulse_in that goes high at least 3 clock cycles before the last gate cycle, and is low for at least one cycle before it rises, adds exactly one to the result. The count starts from zero in every window.
- R5: The count saturates at 2^CNT_W-1 and does not wrap. When more edges arrive than that, count_ovf is 1 for that result; otherwise it is 0.
- R6: With TRIM_EN=1 the result is the saturated count minus floor(window length/10), or 0 if the count is not larger than that amount. With TRIM_EN=0 the result is the saturated count.
- R7: While continuous is high, windows follow each other with no gap. count_valid therefore pulses every gate_len cycles, and each result covers exactly gate_len cycles of edges.
- R8: A start request while gate_len is 0 opens no window and produces no result.
- R9: The window length is captured when the window opens. Changing gate_len while a window is open does not change when that window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; sets the window timing |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Asynchronous pulse train to be measured |
| gate_len | input | GATE_W | Window length in clock cycles; 0 inhibits windows |
| start | input | 1 | Request for a single window, taken while idle |
| continuous | input | 1 | Keeps windows running back to back while high |
| count_out | output | CNT_W | Last result, held between windows |
| count_valid | output | 1 | One-cycle strobe when count_out is updated |
| count_ovf | output | 1 | Count reached saturation in the last window |
| gate_active | output | 1 | High while a window is open |

## Verification
The bench times each window edge against the requested length and places pulses near the close of the window. A counter that drops the final gate cycle, or that loses the synchronizer latency, then reads one count short, and a window off by one cycle shows up as a valid strobe in the wrong cycle. It drives exactly the saturation count and one vector past it, so a counter that wraps, or that raises overflow at the ceiling instead of beyond it, is exposed. Both result variants run side by side on the same stimulus, including cases where the trim amount exceeds the count, which catches a subtraction that underflows. Continuous mode with a free-running source checks that back-to-back windows neither lose nor double-count the edge at the boundary. A length change in mid-window, and a start with zero length, check that the captured length alone decides when a window closes.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
   // zero-scale trim: one tenth of the window length, rounded down
   function automatic logic [31:0] tenth(input logic [31:0] len);
      return len / 32'd10;
   endfunction
endpackage

// File: rtl/gpc_edge_sync.sv
module gpc_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("gpc_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-1:0], async_in};
   end

   assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/gpc_gate_timer.sv
module gpc_gate_timer #(
   parameter int GATE_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GATE_W-1:0] gate_len,
   input  logic              start,
   input  logic              continuous,
   output logic              gate,
   output logic              close,
   output logic [GATE_W-1:0] len_q
);
   logic [GATE_W-1:0] remain_q;
   logic              gate_q;
   logic              len_ok;
   logic              launch;

   assign len_ok = (gate_len != '0);
   assign launch = (start | continuous) & len_ok;
   assign close  = gate_q & (remain_q == GATE_W'(1));
   assign gate   = gate_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q   <= 1'b0;
         remain_q <= '0;
         len_q    <= '0;
      end else if (!gate_q) begin
         if (launch) begin
            gate_q   <= 1'b1;
            remain_q <= gate_len;
            len_q    <= gate_len;
         end
      end else if (close) begin
         if (continuous && len_ok) begin
            remain_q <= gate_len;
            len_q    <= gate_len;
         end else begin
            gate_q   <= 1'b0;
         end
      end else begin
         remain_q <= remain_q - GATE_W'(1);
      end
   end
endmodule

// File: rtl/gpc_edge_accum.sv
module gpc_edge_accum #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate,
   input  logic             rise,
   input  logic             close,
   output logic [CNT_W-1:0] final_cnt,
   output logic             final_ovf
);
   logic [CNT_W-1:0] acc_q;
   logic             ovf_q;
   logic             bump;
   logic             at_max;

   assign bump   = gate & rise;
   assign at_max = &acc_q;

   always_comb begin
      final_cnt = acc_q;
      if (bump && !at_max) final_cnt = acc_q + CNT_W'(1);
      final_ovf = ovf_q | (bump & at_max);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || close) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (bump) begin
         if (at_max) ovf_q <= 1'b1;
         else        acc_q <= acc_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/gpc_result.sv
module gpc_result #(
   parameter int CNT_W   = 16,
   parameter int GATE_W  = 20,
   parameter bit TRIM_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              close,
   input  logic [CNT_W-1:0]  final_cnt,
   input  logic              final_ovf,
   input  logic [GATE_W-1:0] len_q,
   output logic [CNT_W-1:0]  count_out,
   output logic              count_valid,
   output logic              count_ovf
);
   localparam int W = (CNT_W > GATE_W) ? CNT_W : GATE_W;

   logic [CNT_W-1:0] result;

   if (TRIM_EN) begin : g_trim
      logic [W-1:0] cnt_w;
      logic [W-1:0] trim_w;
      logic [W-1:0] diff_w;
      always_comb begin
         cnt_w  = W'(final_cnt);
         trim_w = W'(gpc_pkg::tenth(32'(len_q)));
         diff_w = (cnt_w > trim_w) ? (cnt_w - trim_w) : '0;
         result = diff_w[CNT_W-1:0];
      end
   end else begin : g_plain
      assign result = final_cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_out   <= '0;
         count_valid <= 1'b0;
         count_ovf   <= 1'b0;
      end else begin
         count_valid <= close;
         if (close) begin
            count_out <= result;
            count_ovf <= final_ovf;
         end
      end
   end
endmodule

// File: rtl/gated_pulse_counter.sv
module gated_pulse_counter #(
   parameter int CNT_W       = 16,
   parameter int GATE_W      = 20,
   parameter int SYNC_STAGES = 2,
   parameter bit TRIM_EN     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pulse_in,
   input  logic [GATE_W-1:0] gate_len,
   input  logic              start,
   input  logic              continuous,
   output logic [CNT_W-1:0]  count_out,
   output logic              count_valid,
   output logic              count_ovf,
   output logic              gate_active
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("gated_pulse_counter: CNT_W must lie in 2..32");
   end
   if (GATE_W < 2 || GATE_W > 32) begin : g_bad_gate
      $error("gated_pulse_counter: GATE_W must lie in 2..32");
   end

   logic              rise;
   logic              gate;
   logic              close;
   logic [GATE_W-1:0] len_q;
   logic [CNT_W-1:0]  final_cnt;
   logic              final_ovf;

   gpc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pulse_in), .rise(rise)
   );

   gpc_gate_timer #(.GATE_W(GATE_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .gate_len(gate_len), .start(start),
      .continuous(continuous), .gate(gate), .close(close), .len_q(len_q)
   );

   gpc_edge_accum #(.CNT_W(CNT_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .gate(gate), .rise(rise), .close(close),
      .final_cnt(final_cnt), .final_ovf(final_ovf)
   );

   gpc_result #(.CNT_W(CNT_W), .GATE_W(GATE_W), .TRIM_EN(TRIM_EN)) u_result (
      .clk(clk), .rst_n(rst_n), .close(close), .final_cnt(final_cnt),
      .final_ovf(final_ovf), .len_q(len_q), .count_out(count_out),
      .count_valid(count_valid), .count_ovf(count_ovf)
   );

   assign gate_active = gate;
endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
   parameter int CNT_W   = 16,
   parameter int GATE_W  = 20,
   parameter bit TRIM_EN = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [GATE_W-1:0] gate_len,
   input logic              gate_active,
   input logic [CNT_W-1:0]  count_out,
   input logic              count_valid,
   input logic              count_ovf
);
   // R2
   valid_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_valid |-> $past(gate_active));

   // R8
   zero_len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_active && gate_len == '0) |=> !gate_active);

   // R3
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !count_valid |-> $stable(count_out));

   // R5
   ovf_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(count_ovf) |-> count_valid);

   // R5
   sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!TRIM_EN && count_ovf) |-> (&count_out));
endmodule

bind gated_pulse_counter gpc_checker #(
   .CNT_W(CNT_W), .GATE_W(GATE_W), .TRIM_EN(TRIM_EN)
) u_gpc_checker (
   .clk(clk), .rst_n(rst_n), .gate_len(gate_len), .gate_active(gate_active),
   .count_out(count_out), .count_valid(count_valid), .count_ovf(count_ovf)
);

// File: tb/test_gated_pulse_counter.sv
module test_gated_pulse_counter;
   localparam int CW = 6;
   localparam int GW = 12;
   localparam int MAXC = (1 << CW) - 1;
   localparam int NVEC = 7;
   // {gate length, pulse count, pulse spacing}
   localparam int VEC [NVEC][3] = '{
      '{20, 0, 2}, '{40, 5, 4}, '{200, 30, 5}, '{300, 63, 4},
      '{300, 80, 3}, '{100, 7, 10}, '{12, 3, 3}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pm = 1'b0;
   logic free_run = 1'b0;
   logic start = 1'b0;
   logic cont = 1'b0;
   logic [1:0] ph = 2'd0;
   logic [GW-1:0] glen = '0;
   logic pulse_in;
   logic [CW-1:0] cnt_a, cnt_b;
   logic val_a, val_b, ovf_a, ovf_b, ga_a, ga_b;
   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(negedge clk) ph <= ph + 2'd1;
   assign pulse_in = free_run ? ph[1] : pm;

   gated_pulse_counter #(.CNT_W(CW), .GATE_W(GW), .TRIM_EN(1'b0)) i_gated_pulse_counter (
      .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_len(glen),
      .start(start), .continuous(cont), .count_out(cnt_a),
      .count_valid(val_a), .count_ovf(ovf_a), .gate_active(ga_a)
   );

   gated_pulse_counter #(.CNT_W(CW), .GATE_W(GW), .TRIM_EN(1'b1)) i_gated_pulse_counter_trim (
      .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_len(glen),
      .start(start), .continuous(cont), .count_out(cnt_b),
      .count_valid(val_b), .count_ovf(ovf_b), .gate_active(ga_b)
   );

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   // one window with n clean pulses; returns the cycle of the valid strobe
   task automatic run_window(input int len, input int n, input int sp,
                             input int chg_at, input int chg_len, output int k);
      @(negedge clk);
      glen = GW'(len);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      while (k < 5000) begin
         @(negedge clk);
         k++;
         if (val_a) break;
         if (k == chg_at) glen = GW'(chg_len);
         pm = (k >= 2) && ((k - 2) % sp == 0) && ((k - 2) / sp < n);
      end
      pm = 1'b0;
   endtask

   initial begin
      int k;
      int d;
      int sat;
      int tr;
      int exp_b;
      bit seen;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 count_out in reset", int'(cnt_a), 0);
      check("R1 valid in reset", int'(val_a), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 gate_active after reset", int'(ga_a), 0);
      check("R1 ovf after reset", int'(ovf_a), 0);

      // vector table: R2 R4 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         repeat (4) @(negedge clk);
         run_window(VEC[i][0], VEC[i][1], VEC[i][2], -1, 0, k);
         sat = (VEC[i][1] > MAXC) ? MAXC : VEC[i][1];
         tr = VEC[i][0] / 10;
         exp_b = (sat > tr) ? sat - tr : 0;
         check($sformatf("R2 valid cycle vec%0d", i), k, VEC[i][0]);
         check($sformatf("R4 R5 count vec%0d", i), int'(cnt_a), sat);
         check($sformatf("R5 ovf vec%0d", i), int'(ovf_a), int'(VEC[i][1] > MAXC));
         check($sformatf("R6 trimmed count vec%0d", i), int'(cnt_b), exp_b);
         @(negedge clk);
         check($sformatf("R2 valid one cycle vec%0d", i), int'(val_a), 0);
      end

      // R3: pulses while idle are ignored
      seen = 1'b0;
      d = int'(cnt_a);
      for (int p = 0; p < 5; p++) begin
         @(negedge clk); pm = 1'b1;
         @(negedge clk); pm = 1'b0;
         seen = seen | val_a | ga_a;
      end
      repeat (5) @(negedge clk);
      check("R3 no result while idle", int'(seen), 0);
      check("R3 result held while idle", int'(cnt_a), d);
      run_window(20, 0, 2, -1, 0, k);
      check("R3 idle pulses not counted", int'(cnt_a), 0);

      // R9: length change mid-window
      repeat (4) @(negedge clk);
      run_window(50, 4, 6, 10, 20, k);
      check("R9 captured length", k, 50);
      check("R9 count", int'(cnt_a), 4);

      // R8: zero length
      repeat (4) @(negedge clk);
      glen = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seen = 1'b0;
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         seen = seen | ga_a | val_a | ga_b;
      end
      check("R8 zero length opens nothing", int'(seen), 0);

      // R7: continuous back-to-back windows with a period-4 source
      glen = GW'(40);
      free_run = 1'b1;
      repeat (8) @(negedge clk);
      cont = 1'b1;
      k = 0;
      while (!val_a && k < 500) begin @(negedge clk); k++; end
      for (int w = 0; w < 2; w++) begin
         d = 0;
         do begin @(negedge clk); d++; end while (!val_a && d < 500);
         check($sformatf("R7 window period w%0d", w), d, 40);
         check($sformatf("R7 count w%0d", w), int'(cnt_a), 10);
         check($sformatf("R7 R6 trimmed w%0d", w), int'(cnt_b), 6);
      end
      cont = 1'b0;
      k = 0;
      while (ga_a && k < 500) begin @(negedge clk); k++; end
      check("R7 stops after continuous drops", int'(ga_a), 0);
      free_run = 1'b0;
      repeat (6) @(negedge clk);

      finish_run();
   end
endmodule